// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and one external asynchronous static RAM of 512K bytes. The host makes one single-byte request at a time over a request/ready handshake. The block turns each request into a strobe sequence on the memory pins: a 19-bit address, a shared 8-bit bidirectional data bus, and active-low chip select, write enable and output enable. A completed read is returned to the host with a one-cycle valid pulse.

All phase lengths are whole clock cycles. Each one is derived at elaboration time from nanosecond parameters as ceil(time / clock period), and is never less than one cycle. Writes are ended by the rising edge of write enable, while chip select is still low. Address and write data are latched when the request is accepted, so they stay stable across the whole strobe. A write that follows a read first waits a turnaround phase with every strobe high. This gives the memory time to release the data bus before the block turns on its own data drivers.

The sequencer has seven named states:
- IDLE: all strobes high, ready high.
- TURN: bus turnaround.
- WSETUP: chip select low, data driven.
- WPULSE: write enable low.
- WHOLD: write enable high, chip select still low.
- WREC: write-cycle padding, used only when the cycle-time parameter needs it.
- READ: chip select and output enable low.

The transitions are:
- IDLE goes to READ on a read request.
- IDLE goes to TURN on a write request if the last operation was a read, and to WSETUP otherwise.
- TURN goes to WSETUP.
- WSETUP goes to WPULSE.
- WPULSE goes to WHOLD.
- WHOLD goes to WREC or IDLE.
- WREC goes to IDLE.
- READ goes to IDLE.

A phase moves on at the end of its last counted cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ready is 1, rvalid is 0, and mem_cs_n, mem_we_n and mem_oe_n are all 1.
- R2: Ready is 1 only in IDLE, and then all three strobes are 1. An accepted request (req and ready both 1 at a clock edge) drops ready on the next cycle. A req raised while ready is 0 starts no transaction.
- R3: With the default parameters (10 ns clock), a write holds mem_cs_n at 0 for 6 cycles. Inside that window mem_we_n is 0 for 4 cycles. mem_we_n is never 0 while mem_cs_n is 1. mem_oe_n stays 1 throughout.
- R4: Address and write data are latched at acceptance. While mem_we_n is 0 the address does not change. At the rising edge of mem_we_n, the write pulse has lasted at least 35 ns, the address has been stable at least 40 ns, and the data has been stable at least 25 ns.
- R5: A read holds mem_cs_n and mem_oe_n at 0 for 6 cycles with mem_we_n at 1. rvalid rises 6 cycles after acceptance.
- R6: The byte returned by a read is the last byte written to that address. Data is sampled only after the address-access and output-enable-access times have passed. An address never written reads as 0 in the bench's memory.
- R7: A write accepted when the last completed operation was a read first spends 2 cycles in TURN with all strobes high. Such a write takes 8 cycles from acceptance to ready.
- R8: A write after a write, or any read, takes no turnaround: 6 cycles from acceptance to ready or rvalid.
- R9: The block never drives mem_dq while the memory may still be driving it. In particular, its drivers stay off for at least 20 ns after mem_oe_n rises.
- R10: rvalid is a one-cycle pulse. rdata holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when ready is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host byte address |
| wdata | input | 8 | Host write byte |
| ready | output | 1 | Sequencer idle, request may be taken |
| rdata | output | 8 | Last byte read |
| rvalid | output | 1 | One-cycle pulse when rdata is new |
| mem_addr | output | 19 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
Two functions can meet in the same stretch of cycles: the memory releasing the data bus after a read, and the sequencer turning on its own drivers for the next write. The bench provokes this by accepting a write on the first idle cycle after a read's rvalid, with write data that differs from the byte just read. A memory model in the bench keeps driving for 20 ns after output enable rises and flags any disagreement on the bus. The overlap is judged by that contention count, by the 8-cycle write latency, and by the model's own timing checks at the end of each write.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WREC,
        ST_READ
    } seq_state_t;

    // ceil(t_ns / per_ns), never below one cycle
    function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned per_ns);
        int unsigned c;
        c = (t_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned PULSE  = 4,
    parameter int unsigned REC    = 0,
    parameter int unsigned RLEN   = 6,
    parameter int unsigned TURN   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             phase_last,
    output logic             load,
    output logic [CNT_W-1:0] len,
    output logic             ready,
    output logic             rd_sample,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drv
);
    seq_state_t st, nx;
    logic       after_rd;

    // next-state decision
    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:   if (req) nx = wr ? (after_rd ? ST_TURN : ST_WSETUP) : ST_READ;
            ST_TURN:   if (phase_last) nx = ST_WSETUP;
            ST_WSETUP: if (phase_last) nx = ST_WPULSE;
            ST_WPULSE: if (phase_last) nx = ST_WHOLD;
            ST_WHOLD:  if (phase_last) nx = (REC > 0) ? ST_WREC : ST_IDLE;
            ST_WREC:   if (phase_last) nx = ST_IDLE;
            ST_READ:   if (phase_last) nx = ST_IDLE;
            default:   nx = ST_IDLE;
        endcase
    end

    // length of the phase about to start
    always_comb begin
        unique case (nx)
            ST_TURN:   len = CNT_W'(TURN);
            ST_WPULSE: len = CNT_W'(PULSE);
            ST_WREC:   len = CNT_W'(REC);
            ST_READ:   len = CNT_W'(RLEN);
            default:   len = CNT_W'(1);
        endcase
    end

    assign load      = (nx != st);
    assign ready     = (st == ST_IDLE);
    assign rd_sample = (st == ST_READ) && phase_last;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            after_rd <= 1'b0;
        end else begin
            st <= nx;
            if (st == ST_READ && nx == ST_IDLE) begin
                after_rd <= 1'b1;
            end else if (nx == ST_WSETUP) begin
                after_rd <= 1'b0;
            end
        end
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
            oe_n <= 1'b1;
            drv  <= 1'b0;
        end else begin
            cs_n <= !(nx == ST_WSETUP || nx == ST_WPULSE || nx == ST_WHOLD || nx == ST_READ);
            we_n <= (nx != ST_WPULSE);
            oe_n <= (nx != ST_READ);
            drv  <= (nx == ST_WSETUP || nx == ST_WPULSE || nx == ST_WHOLD);
        end
    end
endmodule

// File: rtl/sram_bus_io.sv
`timescale 1ns/1ps
module sram_bus_io #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              drv,
    input  logic              rd_sample,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= addr_in;
                wdata_q  <= wdata_in;
            end
            if (rd_sample) begin
                rdata <= mem_dq;
            end
            rvalid <= rd_sample;
        end
    end

    assign mem_dq = drv ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_WP_NS       = 35,
    parameter int unsigned T_AW_NS       = 40,
    parameter int unsigned T_DW_NS       = 25,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned T_OE_NS       = 25,
    parameter int unsigned T_HZ_NS       = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int unsigned C_WC   = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WP   = ns2cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned C_AW   = ns2cyc(T_AW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_DW   = ns2cyc(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_RC   = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_AA   = ns2cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned C_OE   = ns2cyc(T_OE_NS, CLK_PERIOD_NS);
    localparam int unsigned TURN   = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
    // setup cycle already counts toward address and data lead time
    localparam int unsigned PUL_A  = (C_WP > C_AW - 1) ? C_WP : C_AW - 1;
    localparam int unsigned PULSE  = (PUL_A > C_DW - 1) ? PUL_A : C_DW - 1;
    localparam int unsigned WBODY  = PULSE + 2;
    localparam int unsigned REC    = (C_WC > WBODY) ? C_WC - WBODY : 0;
    localparam int unsigned RD_A   = (C_AA > C_RC) ? C_AA : C_RC;
    localparam int unsigned RLEN   = (RD_A > C_OE) ? RD_A : C_OE;
    localparam int unsigned MAX_A  = (PULSE > REC) ? PULSE : REC;
    localparam int unsigned MAX_B  = (RLEN > TURN) ? RLEN : TURN;
    localparam int unsigned MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = $clog2(MAXLEN + 1);

    logic             phase_last;
    logic             load;
    logic [CNT_W-1:0] len;
    logic             rd_sample;
    logic             dq_drive;
    logic             accept;

    assign accept = req && ready;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (len),
        .last (phase_last)
    );

    sram_seq_fsm #(
        .CNT_W (CNT_W),
        .PULSE (PULSE),
        .REC   (REC),
        .RLEN  (RLEN),
        .TURN  (TURN)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .wr         (wr),
        .phase_last (phase_last),
        .load       (load),
        .len        (len),
        .ready      (ready),
        .rd_sample  (rd_sample),
        .cs_n       (mem_cs_n),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .drv        (dq_drive)
    );

    sram_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .addr_in   (addr),
        .wdata_in  (wdata),
        .drv       (dq_drive),
        .rd_sample (rd_sample),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ready,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rvalid,
    input logic              drv
);
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && we_n && oe_n));

    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

    p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n);

    p_we_end_cs_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> !cs_n);

    p_no_oe_in_write_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(mem_addr));

    p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    p_drive_after_oe_r9: assert property (@(posedge clk) disable iff (rst)
        drv |-> (oe_n && $past(oe_n) && $past(oe_n, 2)));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .ready    (ready),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .mem_addr (mem_addr),
    .rvalid   (rvalid),
    .drv      (dq_drive)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
    // expected cycle counts from the timing requirements at a 10 ns clock
    localparam int LAT_PLAIN = 6;
    localparam int LAT_TURN  = 8;
    localparam int N_VEC     = 12;
    // {write, address, data, expected read byte, expected latency}
    localparam logic [39:0] VECS [N_VEC] = '{
        {1'b1, 19'h00000, 8'hA5, 8'h00, 4'd6},
        {1'b0, 19'h00000, 8'h00, 8'hA5, 4'd6},
        {1'b1, 19'h7FFFF, 8'h3C, 8'h00, 4'd8},
        {1'b1, 19'h40000, 8'hC3, 8'h00, 4'd6},
        {1'b0, 19'h7FFFF, 8'h00, 8'h3C, 4'd6},
        {1'b0, 19'h40000, 8'h00, 8'hC3, 4'd6},
        {1'b1, 19'h00000, 8'h5A, 8'h00, 4'd8},
        {1'b0, 19'h00000, 8'h00, 8'h5A, 4'd6},
        {1'b1, 19'h2AAAA, 8'hFF, 8'h00, 4'd8},
        {1'b1, 19'h15555, 8'h00, 8'h00, 4'd6},
        {1'b0, 19'h2AAAA, 8'h00, 8'hFF, 4'd6},
        {1'b0, 19'h15555, 8'h00, 8'h00, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid, mem_cs_n, mem_we_n, mem_oe_n;
    logic [7:0]  rdata;
    logic [18:0] mem_addr;
    wire  [7:0]  mem_dq;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] sb [int];
    bit last_rd = 1'b0;

    always #5 clk = ~clk;

    sram_strobe_ctrl u_sram_strobe_ctrl (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // ---------------- asynchronous memory model ----------------
    logic [7:0] mstore [int];
    bit      model_on = 1'b0;
    logic    mdrive = 1'b0;
    logic [7:0] mdata = '0;
    realtime t_addr = 0, t_cs_f = 0, t_oe_f = 0, t_we_f = 0, t_dq = 0, hold_until = 0;
    int viol_addr = 0, viol_time = 0, contention = 0;

    assign mem_dq = mdrive ? mdata : 8'bz;

    always @(mem_addr) begin
        t_addr = $realtime;
        if (model_on && !mem_cs_n && !mem_we_n) viol_addr++;
    end
    always @(negedge mem_cs_n) t_cs_f = $realtime;
    always @(negedge mem_oe_n) t_oe_f = $realtime;
    always @(negedge mem_we_n) t_we_f = $realtime;
    always @(mem_dq) t_dq = $realtime;

    task automatic commit_write();
        realtime now;
        now = $realtime;
        if (now - t_we_f < 35.0) viol_time++;
        if (now - t_addr < 40.0) viol_time++;
        if (now - t_dq < 25.0) viol_time++;
        mstore[int'(mem_addr)] = mem_dq;
    endtask

    always @(posedge mem_we_n) if (model_on && !mem_cs_n) commit_write();
    always @(posedge mem_oe_n) if (model_on && !mem_cs_n && mem_we_n) hold_until = $realtime + 20.0;
    always @(posedge mem_cs_n) begin
        if (model_on && !mem_oe_n && mem_we_n) hold_until = $realtime + 20.0;
        if (model_on && !mem_we_n) commit_write();
    end

    initial begin
        #0.5;
        forever begin
            logic [7:0] cur;
            realtime vt;
            if (model_on && mdrive && mem_dq !== mdata) contention++;
            if (model_on && !mem_cs_n && !mem_oe_n && mem_we_n) begin
                cur = mstore.exists(int'(mem_addr)) ? mstore[int'(mem_addr)] : 8'h00;
                vt = t_addr + 55.0;
                if (t_cs_f + 55.0 > vt) vt = t_cs_f + 55.0;
                if (t_oe_f + 25.0 > vt) vt = t_oe_f + 25.0;
                mdata  = ($realtime >= vt) ? cur : ~cur;
                mdrive = 1'b1;
            end else if ($realtime < hold_until) begin
                mdrive = 1'b1;
            end else begin
                mdrive = 1'b0;
            end
            #1;
        end
    end

    // ---------------- strobe monitor ----------------
    bit mon_on = 1'b0;
    int n_cs = 0, n_we = 0, n_oe = 0, n_bad = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (!mem_cs_n) n_cs++;
            if (!mem_we_n) n_we++;
            if (!mem_oe_n) n_oe++;
            if (!mem_we_n && mem_cs_n) n_bad++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one host transaction; latency = busy negedges before completion
    task automatic issue(input logic w, input logic [18:0] a, input logic [7:0] d,
                         output int lat, output logic [7:0] rd);
        @(negedge clk);
        while (!ready) @(negedge clk);
        n_cs = 0; n_we = 0; n_oe = 0; n_bad = 0; mon_on = 1'b1;
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        req = 1'b0; addr = ~a; wdata = ~d;
        lat = 0;
        forever begin
            @(negedge clk);
            if ((w && ready) || (!w && rvalid) || lat > 40) break;
            lat++;
        end
        rd = rdata;
        mon_on = 1'b0;
    endtask

    task automatic run_op(input logic w, input logic [18:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd, input int exp_lat, input bit shape);
        int lat;
        logic [7:0] rd;
        issue(w, a, d, lat, rd);
        if (w) begin
            chk(last_rd ? "R7 write-after-read latency" : "R8 write latency", lat, exp_lat);
            sb[int'(a)] = d;
            last_rd = 1'b0;
            if (shape) begin
                chk("R3 cs low cycles", n_cs, 6);
                chk("R3 we low cycles", n_we, 4);
                chk("R3 oe low during write", n_oe, 0);
                chk("R3 we low with cs high", n_bad, 0);
            end
        end else begin
            chk("R5 read latency", lat, exp_lat);
            chk("R6 read data", rd, exp_rd);
            last_rd = 1'b1;
            if (shape) begin
                chk("R5 cs low cycles", n_cs, 6);
                chk("R5 oe low cycles", n_oe, 6);
                chk("R5 we low during read", n_we, 0);
            end
        end
    endtask

    initial begin
        #2_000_000;
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 ready in reset", ready, 1);
        chk("R1 rvalid in reset", rvalid, 0);
        chk("R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", ready, 1);
        chk("R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        model_on = 1'b1;

        // vector table
        for (int i = 0; i < N_VEC; i++) begin
            logic [39:0] v;
            v = VECS[i];
            run_op(v[39], v[38:20], v[19:12], v[11:4], int'(v[3:0]), 1'b1);
        end

        // R2: ready drops after accept; req while busy ignored
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 19'h00123; wdata = 8'h11;
        @(posedge clk);
        #1;
        req = 1'b0;
        @(negedge clk);
        chk("R2 ready after accept", ready, 0);
        req = 1'b1; wr = 1'b1; addr = 19'h00456; wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        sb[int'(19'h00123)] = 8'h11;
        last_rd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 no hidden transaction", ready, 1);
        chk("R2 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        run_op(1'b0, 19'h00456, 8'h00, 8'h00, LAT_PLAIN, 1'b0);
        run_op(1'b0, 19'h00123, 8'h00, 8'h11, LAT_PLAIN, 1'b0);

        // R10: rvalid pulse and rdata hold
        @(negedge clk);
        chk("R10 rvalid single cycle", rvalid, 0);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", rdata, 8'h11);

        // R7/R9: write right after a read with differing data
        run_op(1'b1, 19'h00123, 8'hEE, 8'h00, LAT_TURN, 1'b1);

        // random traffic against scoreboard
        for (int i = 0; i < 300; i++) begin
            logic w;
            logic [18:0] a;
            logic [7:0] d, e;
            w = 1'($urandom_range(0, 1));
            a = 19'($urandom) & 19'h7000F;
            d = 8'($urandom);
            e = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
            run_op(w, a, d, e, (w && last_rd) ? LAT_TURN : LAT_PLAIN, 1'b0);
        end

        repeat (4) @(negedge clk);
        chk("R4 address moved during write strobe", viol_addr, 0);
        chk("R4 write timing margins", viol_time, 0);
        chk("R9 bus contention", contention, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule